// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches software timing from both sides. A counter advances on rising edges of a reference clock, and software must service it with a fixed 16-bit key while the counter is inside a permitted window. If the counter runs out the whole period without a service, the block requests a reset. It also requests one when a service arrives before the window opens, and when the written value is not the key. The reset request is a one-cycle pulse. A 2-bit cause code beside it says which fault fired.

The counting reference is one of two clock inputs. Each input is synchronised into the system clock domain, and the block counts its rising edges, so the timeout follows the reference and not the system clock. Configuration sets three things: a power-of-two period, the point at which the window opens (a quarter, a half, three quarters, or the full period, which turns windowing off), and which reference is used. Configuration can only change while the watchdog is disabled.

Writes use a valid/ready port. `wr_ready` is high at all times out of reset, so there is no back-pressure, and a write is taken in any cycle where `wr_valid` and `wr_ready` are both high. `wr_is_cfg` chooses between a service write and a configuration write.

Top module: `win_watchdog`

## Requirements
- R1: Out of reset, `rst_req` is 0, `cause` is 0 and `wr_ready` is 1. The configuration resets to prescale 0, windowing off and reference 0.
- R2: The counter advances only on rising edges of the reference picked by the select bit (bit PS_W+2 of a configuration write). Edges on the other reference have no effect.
- R3: While enabled, a rising edge of the reference that arrives with the counter at period-1 and no service write in that cycle raises `rst_req` for one cycle, with cause 1 (overflow). The counter then restarts at 0.
- R4: While enabled, a service write whose data is not 0x5743 raises `rst_req` in the next cycle, with cause 3 (bad key).
- R5: While enabled and with windowing on, a service write with the correct key and a count below the window start raises `rst_req`, with cause 2 (early).
- R6: A service write with the correct key at or after the window start clears the counter to 0 and raises no request, so regular in-window servicing prevents any reset.
- R7: With window code 3 (full period), a correct service is accepted at any count, including 0.
- R8: The window code sits at bits [PS_W+1:PS_W] of a configuration write. Codes 0, 1 and 2 open the window at 1/4, 2/4 and 3/4 of the period.
- R9: A configuration write made while `en` is high is ignored.
- R10: `cause` keeps its value until the next fault, a rising edge of `en`, or an accepted configuration write (the last two set it to 0). When faults coincide, bad key wins over early. A correct in-window service in the same cycle as the overflow edge wins over the overflow.
- R11: While `en` is low, the counter stays at 0, and service writes and reference edges raise no request.
- R12: The period is 2^(BASE_SHIFT+ps) reference edges, where ps is bits [PS_W-1:0] of a configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk | input | 2 | The two candidate reference clocks, asynchronous to `clk` |
| en | input | 1 | Watchdog enable (level) |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be taken; always 1 out of reset |
| wr_is_cfg | input | 1 | 1 = configuration write, 0 = service write |
| wr_data | input | 16 | Service key or configuration fields |
| rst_req | output | 1 | One-cycle reset request |
| cause | output | 2 | Last fault: 0 none, 1 overflow, 2 early, 3 bad key |

## Verification
The bench builds the block with BASE_SHIFT=2 and PS_W=2. That gives periods of 4 to 32 reference edges, so every timeout, every window boundary and more than one prescale step can be reached in a few hundred cycles. The two references run at different speeds, which makes the overflow timing show which reference is selected. A behavioural model that includes the synchroniser delay is compared with `rst_req` and `cause` on every clock, and scenario checks on top of that cover each fault, the priority cases and the lock on configuration writes.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam logic [15:0] SERVICE_KEY = 16'h5743;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_OVERFLOW = 2'd1,
    CAUSE_EARLY    = 2'd2,
    CAUSE_BADKEY   = 2'd3
  } wd_cause_e;

  typedef enum logic [1:0] {
    WIN_QUARTER = 2'd0,
    WIN_HALF    = 2'd1,
    WIN_3QUART  = 2'd2,
    WIN_OFF     = 2'd3
  } wd_win_e;
endpackage

// File: rtl/wwdt_edge_sync.sv
module wwdt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  // sh[0..STAGES-1] are the synchroniser stages; sh[STAGES] holds the previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/wwdt_cfg_reg.sv
module wwdt_cfg_reg import wwdt_pkg::*; #(
  parameter int PS_W = 4,
  localparam int CFG_W = PS_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr_cfg,
  input  logic [CFG_W-1:0] wr_fields,
  output logic [PS_W-1:0]  ps,
  output wd_win_e          win,
  output logic             ref_sel,
  output logic             cfg_taken
);
  assign cfg_taken = wr_cfg & ~en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps      <= '0;
      win     <= WIN_OFF;
      ref_sel <= 1'b0;
    end else if (cfg_taken) begin
      ps      <= wr_fields[PS_W-1:0];
      win     <= wd_win_e'(wr_fields[PS_W+1:PS_W]);
      ref_sel <= wr_fields[PS_W+2];
    end
  end

  // R9: configuration does not move while the watchdog runs
  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable({ps, win, ref_sel}));
endmodule

// File: rtl/wwdt_limits.sv
module wwdt_limits import wwdt_pkg::*; #(
  parameter int BASE_SHIFT = 5,
  parameter int PS_W       = 4,
  parameter int CNT_W      = BASE_SHIFT + (1 << PS_W)
) (
  input  logic [PS_W-1:0]  ps,
  input  wd_win_e          win,
  output logic [CNT_W-1:0] period_last,
  output logic [CNT_W-1:0] win_start,
  output logic             win_on
);
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] quarter;

  always_comb begin
    period      = {{(CNT_W-1){1'b0}}, 1'b1} << (BASE_SHIFT + int'(ps));
    period_last = period - 1'b1;
    quarter     = period >> 2;
    win_on      = (win != WIN_OFF);
    unique case (win)
      WIN_QUARTER: win_start = quarter;
      WIN_HALF:    win_start = quarter << 1;
      WIN_3QUART:  win_start = quarter + (quarter << 1);
      default:     win_start = '0;
    endcase
  end
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core import wwdt_pkg::*; #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             svc_valid,
  input  logic             svc_key_ok,
  input  logic             cfg_taken,
  input  logic [CNT_W-1:0] period_last,
  input  logic [CNT_W-1:0] win_start,
  input  logic             win_on,
  output logic             rst_req,
  output wd_cause_e        cause
);
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             en_q;
  wd_cause_e        fault;

  always_comb begin
    fault   = CAUSE_NONE;
    cnt_nxt = cnt;
    if (!en) begin
      cnt_nxt = '0;
    end else if (svc_valid && !svc_key_ok) begin
      fault = CAUSE_BADKEY;
    end else if (svc_valid && win_on && (cnt < win_start)) begin
      fault = CAUSE_EARLY;
    end else if (svc_valid) begin
      cnt_nxt = '0;
    end else if (tick) begin
      if (cnt == period_last) fault = CAUSE_OVERFLOW;
      else                    cnt_nxt = cnt + 1'b1;
    end
    if (fault != CAUSE_NONE) cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      en_q    <= 1'b0;
      rst_req <= 1'b0;
      cause   <= CAUSE_NONE;
    end else begin
      cnt     <= cnt_nxt;
      en_q    <= en;
      rst_req <= (fault != CAUSE_NONE);
      if (fault != CAUSE_NONE)              cause <= fault;
      else if ((en && !en_q) || cfg_taken)  cause <= CAUSE_NONE;
    end
  end

  // R12: the count never passes the last value of the period
  p_cnt_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= period_last);
  // R3: every request carries a cause
  p_req_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cause != CAUSE_NONE));
  // R5: a correct key below the window start gives an early fault
  p_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && svc_valid && svc_key_ok && win_on && cnt < win_start) |=>
      (rst_req && cause == CAUSE_EARLY));
  // R11: nothing is requested while disabled
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rst_req);
  // R10: with no write and no edge, a running watchdog keeps its cause
  p_cause_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && en_q && !svc_valid && !tick) |=> $stable(cause));
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog import wwdt_pkg::*; #(
  parameter int BASE_SHIFT  = 5,
  parameter int PS_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ref_clk,
  input  logic        en,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic        wr_is_cfg,
  input  logic [15:0] wr_data,
  output logic        rst_req,
  output logic [1:0]  cause
);
  localparam int NUM_REF = 2;
  localparam int CNT_W   = BASE_SHIFT + (1 << PS_W);
  localparam int CFG_W   = PS_W + 3;

  logic [NUM_REF-1:0] ref_rise;
  logic [PS_W-1:0]    ps;
  wd_win_e            win;
  logic               ref_sel;
  logic               cfg_taken;
  logic [CNT_W-1:0]   period_last, win_start;
  logic               win_on;
  logic               wr_take;
  wd_cause_e          cause_e;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_ready <= 1'b0;
    else        wr_ready <= 1'b1;
  end

  assign wr_take = wr_valid & wr_ready;

  for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
    wwdt_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_in(ref_clk[g]), .rise(ref_rise[g])
    );
  end

  wwdt_cfg_reg #(.PS_W(PS_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .en(en),
    .wr_cfg(wr_take & wr_is_cfg), .wr_fields(wr_data[CFG_W-1:0]),
    .ps(ps), .win(win), .ref_sel(ref_sel), .cfg_taken(cfg_taken)
  );

  wwdt_limits #(.BASE_SHIFT(BASE_SHIFT), .PS_W(PS_W), .CNT_W(CNT_W)) lim_i (
    .ps(ps), .win(win), .period_last(period_last),
    .win_start(win_start), .win_on(win_on)
  );

  wwdt_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(ref_rise[ref_sel]),
    .svc_valid(wr_take & ~wr_is_cfg), .svc_key_ok(wr_data == SERVICE_KEY),
    .cfg_taken(cfg_taken), .period_last(period_last), .win_start(win_start),
    .win_on(win_on), .rst_req(rst_req), .cause(cause_e)
  );

  assign cause = cause_e;

  // R4: a wrong key on a running watchdog is reported next cycle
  p_badkey_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_valid && wr_ready && !wr_is_cfg && wr_data != SERVICE_KEY) |=>
      (rst_req && cause == 2'd3));
  // R1: the write port never pushes back once out of reset
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wr_ready);
endmodule

// File: tb/win_watchdog_tb_top.sv
module win_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_SHIFT = 2;
  localparam int PS_W       = 2;
  localparam int KEY        = 16'h5743;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ref_clk = 2'b00;
  logic        en = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic        wr_is_cfg = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic        rst_req;
  logic [1:0]  cause;

  int checks = 0, failures = 0, cyc = 0, pulses = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_cnt = 0, m_ps = 0, m_win = 3, m_sel = 0, m_cause = 0, m_req = 0, m_en_q = 0;
  int h1[2] = '{0, 0}, h2[2] = '{0, 0}, h3[2] = '{0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  win_watchdog #(.BASE_SHIFT(BASE_SHIFT), .PS_W(PS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .en(en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_is_cfg(wr_is_cfg),
    .wr_data(wr_data), .rst_req(rst_req), .cause(cause)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic model_edge();
    int period, wstart, fault, tick[2];
    if (!rst_n) begin
      m_cnt = 0; m_ps = 0; m_win = 3; m_sel = 0; m_cause = 0; m_req = 0; m_en_q = 0;
      for (int i = 0; i < 2; i++) begin h1[i] = 0; h2[i] = 0; h3[i] = 0; end
      return;
    end
    for (int i = 0; i < 2; i++) begin
      tick[i] = h2[i] & ~h3[i] & 1;
      h3[i] = h2[i]; h2[i] = h1[i]; h1[i] = ref_clk[i];
    end
    period = 1 << (BASE_SHIFT + m_ps);
    wstart = (period / 4) * (m_win + 1);
    fault = 0;
    if (!en) m_cnt = 0;
    else if (wr_valid && !wr_is_cfg) begin
      if (wr_data != KEY) fault = 3;
      else if (m_win != 3 && m_cnt < wstart) fault = 2;
      else m_cnt = 0;
    end else if (tick[m_sel] != 0) begin
      if (m_cnt == period - 1) fault = 1;
      else m_cnt++;
    end
    if (fault != 0) m_cnt = 0;
    m_req = (fault != 0);
    if (fault != 0) m_cause = fault;
    else if ((en && !m_en_q) || (!en && wr_valid && wr_is_cfg)) m_cause = 0;
    if (!en && wr_valid && wr_is_cfg) begin
      m_ps  = wr_data[PS_W-1:0];
      m_win = wr_data[PS_W+1:PS_W];
      m_sel = wr_data[PS_W+2];
    end
    m_en_q = en;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cyc++;
    if (rst_n) begin
      check(cur_req, rst_req, m_req, "rst_req vs model");
      check(cur_req, cause, m_cause, "cause vs model");
      if (rst_req) pulses++;
    end
    // reference A rises every 4 cycles, reference B every 6
    ref_clk[0] = ((cyc / 2) % 2) != 0;
    ref_clk[1] = ((cyc / 3) % 2) != 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input bit is_cfg, input int data);
    wr_valid = 1'b1; wr_is_cfg = is_cfg; wr_data = data[15:0];
    step();
    wr_valid = 1'b0; wr_is_cfg = 1'b0;
  endtask

  function automatic int cfgw(input int ps, input int win, input int sel);
    return ps | (win << PS_W) | (sel << (PS_W + 2));
  endfunction

  initial begin
    run(3);
    rst_n = 1'b1;
    run(2);
    cur_req = "R1";
    check("R1", wr_ready, 1, "wr_ready after reset");
    check("R1", rst_req, 0, "rst_req after reset");
    check("R1", cause, 0, "cause after reset");

    // R11: disabled block ignores services and reference edges
    cur_req = "R11";
    wr(0, 16'h1234); wr(0, KEY);
    pulses = 0; run(40);
    check("R11", pulses, 0, "requests while disabled");

    // R3/R12: overflow at prescale 0 on reference A
    cur_req = "R3";
    wr(1, cfgw(0, 3, 0));
    en = 1'b1; pulses = 0; run(24);
    check("R3", pulses >= 1, 1, "overflow request seen");
    check("R3", cause, 1, "overflow cause");
    run(30);
    en = 1'b0; run(2);

    // R12: prescale 1 doubles the period
    cur_req = "R12";
    wr(1, cfgw(1, 3, 0));
    en = 1'b1; pulses = 0; run(25);
    check("R12", pulses, 0, "no request before doubled period");
    run(40);
    check("R12", pulses >= 1, 1, "request after doubled period");
    en = 1'b0; run(2);

    // R2: reference B is slower
    cur_req = "R2";
    wr(1, cfgw(0, 3, 1));
    en = 1'b1; pulses = 0; run(17);
    check("R2", pulses, 0, "no early overflow on slow reference");
    run(20);
    check("R2", pulses >= 1, 1, "overflow on slow reference");
    en = 1'b0; run(2);

    // R10: cause cleared by configuration write, held otherwise
    cur_req = "R10";
    check("R10", cause, 1, "cause held after disable");
    wr(1, cfgw(2, 1, 0));
    check("R10", cause, 0, "cause cleared by config write");

    // R5/R8: half window, service at once is early
    cur_req = "R5";
    en = 1'b1; run(3);
    wr(0, KEY);
    check("R5", cause, 2, "early service cause");
    check("R5", rst_req, 1, "early service request");

    // R6/R8: regular in-window services keep it alive (period 64 cycles, window from 32)
    cur_req = "R6";
    pulses = 0;
    for (int k = 0; k < 6; k++) begin run(39); wr(0, KEY); end
    check("R6", pulses, 0, "no request with in-window service");
    check("R6", cause, 2, "cause still holds earlier fault");

    // R9: configuration write while enabled is ignored (period stays 64 cycles)
    cur_req = "R9";
    wr(1, cfgw(0, 3, 0));
    pulses = 0; run(20);
    check("R9", pulses, 0, "locked config did not shorten period");

    // R4: bad key, and bad key wins over early
    cur_req = "R4";
    wr(0, 16'h5744);
    check("R4", cause, 3, "bad key cause");
    check("R4", rst_req, 1, "bad key request");
    cur_req = "R10";
    run(1);
    wr(0, 16'h0000);
    check("R10", cause, 3, "bad key wins over early");
    en = 1'b0; run(2);
    en = 1'b1; run(1);
    check("R10", cause, 0, "cause cleared on enable");
    en = 1'b0; run(2);

    // R8: quarter window at prescale 2 (window from 4 edges = about 16 cycles)
    cur_req = "R8";
    wr(1, cfgw(2, 0, 0));
    en = 1'b1; run(24);
    wr(0, KEY);
    check("R8", cause, 0, "quarter window accepts service");
    run(5);
    wr(0, KEY);
    check("R8", cause, 2, "service right after clear is early");
    en = 1'b0; run(2);

    // R7: full window accepts service at count 0
    cur_req = "R7";
    wr(1, cfgw(2, 3, 0));
    en = 1'b1; run(1);
    wr(0, KEY); wr(0, KEY);
    check("R7", cause, 0, "service accepted at any count");
    check("R7", rst_req, 0, "no request with window off");
    en = 1'b0; run(2);

    // R10: service landing on overflow edges over a sweep of offsets
    cur_req = "R10";
    wr(1, cfgw(0, 3, 0));
    en = 1'b1;
    for (int k = 0; k < 8; k++) begin run(12 + k); wr(0, KEY); end
    en = 1'b0; run(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule